// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a three-wire serial audio stream and turns it into parallel stereo samples. The three wires are a bit clock, a word-select line and a data line. The block runs directly on the bit clock. It samples word select and data on every rising edge. Each stereo frame is 64 bit clocks long: a 32-clock left slot followed by a 32-clock right slot. When both halves of a frame have arrived, the block presents them as 24-bit words and raises a one-cycle strobe.

A 3-bit framing code tells the block where the sample sits inside each slot and in which bit order it arrives. There are seven framings:
- the classic one-bit-delayed stereo framing;
- left-justified;
- right-justified with the least significant bit first;
- right-justified with the most significant bit first, at 24, 20, 18 and 16 bits.

Shorter words are sign-extended to 24 bits. The code comes from one of two places: a three-bit field held in a control register elsewhere in the chip, or three configuration pins. The pins win unless all three are low.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is asserted, and until the first frame is delivered after reset, `left_out` and `right_out` are zero and `out_valid` is low. The active framing after reset is code 000.
- R2: Code 000 (one-bit-delayed framing): word select low marks the left slot. The 24-bit sample is sent MSB first, and its MSB is sampled on the second rising edge of the slot (slot index 1). The slot index counts rising edges from 0, starting at the edge where the new word-select level is first seen.
- R3: Code 001 (left-justified): word select high marks the left slot. The 24-bit sample is sent MSB first on slot indices 0 through 23.
- R4: Code 010 (right-justified, LSB first): word select high marks the left slot. The 24 bits occupy slot indices 8 through 31. The first bit received becomes bit 0 of the output and the 24th bit received becomes bit 23.
- R5: Codes 011, 100, 101 and 110 (right-justified, MSB first, 24/20/18/16 bits): word select high marks the left slot. The last bit of the word falls on slot index 31. Words shorter than 24 bits are sign-extended from their top bit.
- R6: Data bits that fall outside the active framing's bit window have no effect on the output words.
- R7: For each complete left/right pair, `out_valid` is high for exactly one cycle. That cycle follows the rising edge that starts the next frame's left slot. In that cycle `left_out` and `right_out` carry the pair, and they hold it until the next pulse.
- R8: When `fmt_pins` is non-zero, it selects the framing and `fmt_reg` is ignored. When `fmt_pins` is 000, `fmt_reg` selects the framing.
- R9: A selected code of 111, from either source, is treated as code 000.
- R10: A new framing code takes effect only on the rising edge that starts a slot which is a left slot under the new code. A slot already in progress keeps the framing it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; the block's only clock, sampled on rising edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_sel | input | 1 | Channel select line; each change starts a new slot |
| ser_data | input | 1 | Serial sample data |
| fmt_pins | input | 3 | Framing code from configuration pins; non-zero overrides the register |
| fmt_reg | input | 3 | Framing code from the control register field |
| left_out | output | 24 | Left sample of the last complete frame, sign-extended |
| right_out | output | 24 | Right sample of the last complete frame, sign-extended |
| out_valid | output | 1 | One-cycle strobe marking a new left/right pair |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe never lasts longer than one cycle;
- a strobe only rises after a slot start;
- the active framing changes only on a slot-start edge;
- in 16-bit mode, both output words are properly sign-extended.

Other properties can only be shown by the bench's scenarios:
- the bit placement and bit order of each of the seven framings;
- the pin-over-register priority and the fallback of code 111;
- that a code change in mid-frame leaves the current frame decoded in the old framing.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

  localparam int SAMPLE_W = 24;
  localparam int SLOT_LEN = 32;
  localparam int IDX_W    = $clog2(SLOT_LEN);
  localparam int WID_W    = $clog2(SAMPLE_W + 1);
  localparam int CODE_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    FMT_DELAYED = 3'b000,
    FMT_LEFTJ   = 3'b001,
    FMT_RJ_LSB  = 3'b010,
    FMT_RJ24    = 3'b011,
    FMT_RJ20    = 3'b100,
    FMT_RJ18    = 3'b101,
    FMT_RJ16    = 3'b110
  } fmt_e;

  function automatic logic fmt_right_just(input fmt_e f);
    return (f != FMT_DELAYED) && (f != FMT_LEFTJ);
  endfunction

  function automatic int fmt_bits(input fmt_e f);
    case (f)
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      FMT_RJ16: return 16;
      default:  return SAMPLE_W;
    endcase
  endfunction

  function automatic logic [WID_W-1:0] fmt_width(input fmt_e f);
    return WID_W'(fmt_bits(f));
  endfunction

  function automatic logic [IDX_W-1:0] fmt_first(input fmt_e f);
    if (fmt_right_just(f)) return IDX_W'(SLOT_LEN - fmt_bits(f));
    if (f == FMT_DELAYED)  return IDX_W'(1);
    return '0;
  endfunction

  function automatic logic [IDX_W-1:0] fmt_last(input fmt_e f);
    if (fmt_right_just(f)) return IDX_W'(SLOT_LEN - 1);
    return IDX_W'(int'(fmt_first(f)) + fmt_bits(f) - 1);
  endfunction

  function automatic logic fmt_left_high(input fmt_e f);
    return (f != FMT_DELAYED);
  endfunction

  function automatic logic fmt_lsb_first(input fmt_e f);
    return (f == FMT_RJ_LSB);
  endfunction

endpackage

// File: rtl/ser_audio_fmt_select.sv
module ser_audio_fmt_select
  import ser_audio_pkg::*;
(
  input  logic [CODE_W-1:0] pin_code,
  input  logic [CODE_W-1:0] reg_code,
  output fmt_e              chosen
);

  logic [CODE_W-1:0] raw_code;

  always_comb begin
    // configuration pins dominate unless all of them are low
    raw_code = (pin_code == '0) ? reg_code : pin_code;
    if (raw_code == {CODE_W{1'b1}}) chosen = FMT_DELAYED;
    else                            chosen = fmt_e'(raw_code);
  end

endmodule

// File: rtl/ser_audio_slot_timer.sv
module ser_audio_slot_timer
  import ser_audio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ws_in,
  output logic             slot_start,
  output logic [IDX_W-1:0] idx
);

  logic             ws_q;
  logic             primed_q;
  logic [IDX_W-1:0] cnt_q;

  always_comb begin
    slot_start = primed_q && (ws_in != ws_q);
    if (slot_start)                          idx = '0;
    else if (cnt_q == IDX_W'(SLOT_LEN - 1))  idx = cnt_q;
    else                                     idx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
      cnt_q    <= IDX_W'(SLOT_LEN - 1);
    end else begin
      ws_q     <= ws_in;
      primed_q <= 1'b1;
      cnt_q    <= idx;
    end
  end

  // a slot index may only return to zero on a word-select change
  assert_idx_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ws_in == ws_q) |=> (cnt_q != '0 || $past(cnt_q) == '0));

endmodule

// File: rtl/ser_audio_bit_capture.sv
module ser_audio_bit_capture
  import ser_audio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_in,
  input  logic                slot_start,
  input  logic [IDX_W-1:0]    idx,
  input  logic [IDX_W-1:0]    win_first,
  input  logic [IDX_W-1:0]    win_last,
  input  logic                win_lsb_first,
  input  logic [WID_W-1:0]    done_width,
  output logic [SAMPLE_W-1:0] word
);

  logic [SAMPLE_W-1:0] sh_q;
  logic [SAMPLE_W-1:0] sh_d;
  logic [SAMPLE_W-1:0] base;
  logic                in_win;
  logic                sh_en;

  always_comb begin
    base   = slot_start ? '0 : sh_q;
    in_win = (idx >= win_first) && (idx <= win_last);
    sh_en  = in_win || slot_start;
    sh_d   = base;
    if (in_win) begin
      if (win_lsb_first) sh_d = {sd_in, base[SAMPLE_W-1:1]};
      else               sh_d = {base[SAMPLE_W-2:0], sd_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // sign-extend the finished slot word from its top received bit
  generate
    for (genvar b = 0; b < SAMPLE_W; b++) begin : g_ext
      localparam logic [WID_W-1:0] BPOS = WID_W'(b);
      assign word[b] = (BPOS < done_width) ? sh_q[b] : sh_q[done_width - 1'b1];
    end
  endgenerate

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
  import ser_audio_pkg::*;
(
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                word_sel,
  input  logic                ser_data,
  input  logic [CODE_W-1:0]   fmt_pins,
  input  logic [CODE_W-1:0]   fmt_reg,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                out_valid
);

  // reset: asserted asynchronously, released on the bit clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fmt_e                sel_fmt;
  fmt_e                win_fmt;
  fmt_e                fmt_act_q, fmt_act_d;
  logic                slot_start;
  logic [IDX_W-1:0]    idx;
  logic                new_left;
  logic [SAMPLE_W-1:0] cap_word;

  logic                slot_left_q, slot_left_d;
  logic                slot_ok_q,   slot_ok_d;
  logic                left_got_q,  left_got_d;
  logic [SAMPLE_W-1:0] left_hold_q, left_hold_d;
  logic [SAMPLE_W-1:0] left_out_d, right_out_d;
  logic                valid_d;
  logic                upd_en;

  ser_audio_fmt_select u_sel (
    .pin_code (fmt_pins),
    .reg_code (fmt_reg),
    .chosen   (sel_fmt)
  );

  ser_audio_slot_timer u_timer (
    .clk        (bit_clk),
    .rst_n      (rst_int_n),
    .ws_in      (word_sel),
    .slot_start (slot_start),
    .idx        (idx)
  );

  always_comb begin
    new_left = (word_sel == fmt_left_high(sel_fmt));
    win_fmt  = (slot_start && new_left) ? sel_fmt : fmt_act_q;
  end

  ser_audio_bit_capture u_cap (
    .clk           (bit_clk),
    .rst_n         (rst_int_n),
    .sd_in         (ser_data),
    .slot_start    (slot_start),
    .idx           (idx),
    .win_first     (fmt_first(win_fmt)),
    .win_last      (fmt_last(win_fmt)),
    .win_lsb_first (fmt_lsb_first(win_fmt)),
    .done_width    (fmt_width(fmt_act_q)),
    .word          (cap_word)
  );

  // frame assembly: next-state
  always_comb begin
    fmt_act_d   = fmt_act_q;
    slot_left_d = slot_left_q;
    slot_ok_d   = slot_ok_q;
    left_got_d  = left_got_q;
    left_hold_d = left_hold_q;
    left_out_d  = left_out;
    right_out_d = right_out;
    valid_d     = 1'b0;
    if (slot_start) begin
      slot_ok_d   = 1'b1;
      slot_left_d = new_left;
      if (slot_ok_q && slot_left_q) begin
        left_hold_d = cap_word;
        left_got_d  = 1'b1;
      end
      if (slot_ok_q && !slot_left_q && left_got_q) begin
        left_out_d  = left_hold_q;
        right_out_d = cap_word;
        valid_d     = 1'b1;
        left_got_d  = 1'b0;
      end
      if (new_left) begin
        fmt_act_d = sel_fmt;
        if (sel_fmt != fmt_act_q) left_got_d = 1'b0;
      end
    end
  end

  assign upd_en = slot_start || out_valid;

  // frame assembly: registers
  always_ff @(posedge bit_clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      fmt_act_q   <= FMT_DELAYED;
      slot_left_q <= 1'b0;
      slot_ok_q   <= 1'b0;
      left_got_q  <= 1'b0;
      left_hold_q <= '0;
      left_out    <= '0;
      right_out   <= '0;
      out_valid   <= 1'b0;
    end else if (upd_en) begin
      fmt_act_q   <= fmt_act_d;
      slot_left_q <= slot_left_d;
      slot_ok_q   <= slot_ok_d;
      left_got_q  <= left_got_d;
      left_hold_q <= left_hold_d;
      left_out    <= left_out_d;
      right_out   <= right_out_d;
      out_valid   <= valid_d;
    end
  end

  assert_valid_single_R7: assert property (@(posedge bit_clk) disable iff (!rst_int_n)
    out_valid |=> !out_valid);

  assert_valid_after_start_R7: assert property (@(posedge bit_clk) disable iff (!rst_int_n)
    $rose(out_valid) |-> $past(slot_start));

  assert_fmt_hold_R10: assert property (@(posedge bit_clk) disable iff (!rst_int_n)
    !slot_start |=> $stable(fmt_act_q));

  assert_sign_ext16_R5: assert property (@(posedge bit_clk) disable iff (!rst_int_n)
    (out_valid && $past(fmt_act_q) == FMT_RJ16) |->
      (right_out[SAMPLE_W-1:16] == {(SAMPLE_W-16){right_out[15]}} &&
       left_out[SAMPLE_W-1:16]  == {(SAMPLE_W-16){left_out[15]}}));

endmodule

// File: tb/sim_ser_audio_rx.sv
`timescale 1ns/1ps
module sim_ser_audio_rx;

  logic        bit_clk = 1'b0;
  logic        rst_n;
  logic        word_sel;
  logic        ser_data;
  logic [2:0]  fmt_pins;
  logic [2:0]  fmt_reg;
  logic [23:0] left_out;
  logic [23:0] right_out;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [23:0] got_l = '0;
  logic [23:0] got_r = '0;

  always #2 bit_clk = ~bit_clk;

  ser_audio_rx u0 (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .word_sel  (word_sel),
    .ser_data  (ser_data),
    .fmt_pins  (fmt_pins),
    .fmt_reg   (fmt_reg),
    .left_out  (left_out),
    .right_out (right_out),
    .out_valid (out_valid)
  );

  always @(negedge bit_clk) begin
    if (out_valid) begin
      got_l = left_out;
      got_r = right_out;
      vcount++;
    end
  end

  function automatic int width_of(input logic [2:0] c);
    case (c)
      3'd4:    return 20;
      3'd5:    return 18;
      3'd6:    return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] ext(input logic [2:0] c, input logic [23:0] v);
    logic [23:0] r;
    int n;
    n = width_of(c);
    r = v;
    for (int b = 0; b < 24; b++) if (b >= n) r[b] = v[n-1];
    return r;
  endfunction

  function automatic logic slot_bit(input logic [2:0] c, input logic [23:0] v, input int i);
    int n;
    n = width_of(c);
    case (c)
      3'd0:    return (i >= 1 && i <= 24) ? v[24-i] : 1'b1;
      3'd1:    return (i <= 23) ? v[23-i] : 1'b1;
      3'd2:    return (i >= 8) ? v[i-8] : 1'b1;
      default: return (i >= 32 - n) ? v[31-i] : 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_slot(input logic [2:0] c, input bit is_left, input logic [23:0] v);
    logic lvl;
    lvl = (c == 3'd0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 32; i++) begin
      @(negedge bit_clk);
      word_sel = is_left ? lvl : ~lvl;
      ser_data = slot_bit(c, v, i);
    end
  endtask

  task automatic send_frame(input logic [2:0] c, input logic [23:0] l, input logic [23:0] r);
    drive_slot(c, 1'b1, l);
    drive_slot(c, 1'b0, r);
  endtask

  // one framing scenario: settle, send two pairs, check each plus pulse count
  task automatic run_fmt(input string tag, input logic [2:0] pins, input logic [2:0] regc,
                         input logic [2:0] eff, input logic [23:0] al, input logic [23:0] ar,
                         input logic [23:0] bl, input logic [23:0] br);
    int n0;
    fmt_pins = pins;
    fmt_reg  = regc;
    send_frame(eff, 24'h0, 24'h0);
    send_frame(eff, 24'h0, 24'h0);
    send_frame(eff, al, ar);
    send_frame(eff, bl, br);
    check({tag, " left A"},  got_l, ext(eff, al));
    check({tag, " right A"}, got_r, ext(eff, ar));
    n0 = vcount;
    send_frame(eff, 24'h0, 24'h0);
    check({tag, " left B"},  got_l, ext(eff, bl));
    check({tag, " right B"}, got_r, ext(eff, br));
    check({tag, " R7 one pulse per frame"}, 24'(vcount - n0), 24'd1);
    check({tag, " R7 strobe low mid-frame"}, {23'd0, out_valid}, 24'd0);
  endtask

  task automatic t_reset();
    check("R1 left after reset",  left_out,  24'h0);
    check("R1 right after reset", right_out, 24'h0);
    check("R1 valid after reset", {23'd0, out_valid}, 24'd0);
  endtask

  // code change in the middle of a frame must wait for the next left slot
  task automatic t_boundary();
    fmt_pins = 3'b000;
    fmt_reg  = 3'b011;
    send_frame(3'd3, 24'h0, 24'h0);
    send_frame(3'd3, 24'h0, 24'h0);
    drive_slot(3'd3, 1'b1, 24'h128456);
    fmt_reg = 3'b110;
    drive_slot(3'd3, 1'b0, 24'h3BF00D);
    send_frame(3'd6, 24'h00C001, 24'h007FFF);
    check("R10 left keeps old framing",  got_l, 24'h128456);
    check("R10 right keeps old framing", got_r, 24'h3BF00D);
    send_frame(3'd6, 24'h0, 24'h0);
    check("R10 left new framing",  got_l, 24'hFFC001);
    check("R10 right new framing", got_r, 24'h007FFF);
  endtask

  initial begin
    rst_n    = 1'b0;
    word_sel = 1'b1;
    ser_data = 1'b0;
    fmt_pins = 3'b000;
    fmt_reg  = 3'b000;
    repeat (4) @(negedge bit_clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge bit_clk);
    t_reset();
    run_fmt("R2 delayed",      3'b000, 3'b000, 3'd0, 24'hA5C3E1, 24'h13579B, 24'h800001, 24'h7FFFFE);
    run_fmt("R3 R6 leftj",     3'b000, 3'b001, 3'd1, 24'h001234, 24'hF0F0F0, 24'h000001, 24'h800000);
    run_fmt("R4 lsb first",    3'b000, 3'b010, 3'd2, 24'h800001, 24'h123456, 24'h00FF00, 24'hC00003);
    run_fmt("R5 rj24",         3'b000, 3'b011, 3'd3, 24'h8ABCDE, 24'h012345, 24'h7F0001, 24'hFFFFFF);
    run_fmt("R5 rj20",         3'b000, 3'b100, 3'd4, 24'h08ABCD, 24'h07FFFF, 24'h080000, 24'h012345);
    run_fmt("R5 rj18",         3'b000, 3'b101, 3'd5, 24'h020001, 24'h01FFFF, 24'h03AAAA, 24'h015555);
    run_fmt("R5 R6 rj16",      3'b000, 3'b110, 3'd6, 24'h007ABC, 24'h008001, 24'h00FFFF, 24'h000000);
    run_fmt("R8 pins win",     3'b011, 3'b001, 3'd3, 24'h9ABCDE, 24'h2468AC, 24'h000F00, 24'hF000F0);
    run_fmt("R8 reg path",     3'b000, 3'b001, 3'd1, 24'h55AA55, 24'hAA55AA, 24'h123123, 24'h321321);
    run_fmt("R9 pins 111",     3'b111, 3'b010, 3'd0, 24'hC0FFEE, 24'h0BEEF0, 24'h010203, 24'hFEDCBA);
    run_fmt("R9 reg 111",      3'b000, 3'b111, 3'd0, 24'h765432, 24'h89ABCD, 24'h7F7F7F, 24'h808080);
    t_boundary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bit_clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule